// File: doc/BRIEF.md
# Serial Shift-Row Storage Array

This block is a cycle-level model of a small storage array with `ROWS` rows of `BITS` bits each. Every row is a chain of identical one-bit cells linked like a shift register. All rows share one serial data input. Each row has its own read/write enable, and each row has its own serial output taken from the last cell of its chain.

Every cell has a small drive stage that feeds the storage element two signals. The first is the complement of (row enable XOR incoming data bit). The second is the incoming data bit itself. The storage element decodes its pair of drives into one of two operations, named in the enum `cell_op_e`:
- `OP_WRITE`: the two drives are equal, and the cell overwrites its content with the data bit.
- `OP_HOLD`: the two drives differ, and the cell keeps its content.

These are the only states of each cell. A cell moves from `OP_HOLD` to `OP_WRITE` when its row enable is 1 at a rising clock edge, and from `OP_WRITE` back to `OP_HOLD` when the enable is 0.

An enabled row therefore shifts one place per clock. The bit leaving the far end is presented on the row's output in the same cycle as the new bit enters. A full-row access always takes `BITS` enabled cycles, whichever row is used.

Top module: `shift_row_memory`

## Requirements
- R1: Reset (active-low `rst_n`) clears every stored bit to 0, so the first `BITS` bits unloaded from any row after reset are 0.
- R2: While a row's enable is 1 at a rising edge, cell 0 of that row takes `ser_in`, and each cell i>0 takes the value cell i-1 held before the edge.
- R3: An enabled cell takes its incoming data bit whatever it held before, for both data values 0 and 1.
- R4: While a row's enable is 0 at a rising edge, every bit of that row keeps its value, whatever `ser_in` does.
- R5: While a row's enable is 0, that row's `ser_out` bit is 0.
- R6: While a row's enable is 1, that row's `ser_out` bit shows the content of cell `BITS`-1 in the same cycle that new data enters cell 0. Reading and writing happen together.
- R7: Several rows enabled in the same cycle all shift in the same `ser_in` bit, and each shifts independently of the other rows.
- R8: A bit pattern shifted into a row appears on `ser_out`, first bit first, after exactly `BITS` enabled cycles. This latency is the same for every row.
- R9: The enables are sampled only at rising clock edges. Pausing a row between enabled cycles does not lose or repeat any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_rw | input | ROWS | Per-row read/write enable, bit r belongs to row r |
| ser_in | input | 1 | Shared serial data input into cell 0 of every row |
| ser_out | output | ROWS | Per-row serial output from cell `BITS`-1, 0 when the row is idle |

## Verification
Two functions share a single cycle in this block: reading the bit that leaves cell `BITS`-1 and writing the new bit into cell 0 of the same row. The bench provokes this in two steps. It first fills every row with one pattern, then shifts a different pattern into a single row while watching that row's output. Each cycle's output must equal the old pattern, and the new pattern must come back intact when the row is later unloaded. The bench also pauses one row part-way through a transfer and toggles `ser_in` against idle rows, to show that reads and writes only happen on enabled edges.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic {
        OP_HOLD  = 1'b0,
        OP_WRITE = 1'b1
    } cell_op_e;
endpackage

// File: rtl/srm_drive.sv
module srm_drive (
    input  logic rw,
    input  logic din,
    output logic drv_a,
    output logic drv_b
);
    always_comb begin
        drv_a = ~(rw ^ din);
        drv_b = din;
    end
endmodule

// File: rtl/srm_cell.sv
module srm_cell
    import srm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drv_a,
    input  logic drv_b,
    output logic q
);
    cell_op_e op;

    always_comb begin
        op = (drv_a == drv_b) ? OP_WRITE : OP_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_WRITE: q <= drv_b;
                OP_HOLD:  q <= q;
                default:  q <= q;
            endcase
        end
    end

    // R3
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a == drv_b) |=> (q == $past(drv_b)));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_a != drv_b) |=> (q == $past(q)));
endmodule

// File: rtl/srm_row.sv
module srm_row #(
    parameter int BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rw,
    input  logic ser_in,
    output logic ser_out
);
    logic [BITS-1:0] bits_q;
    logic [BITS-1:0] link;

    for (genvar i = 0; i < BITS; i++) begin : g_blk
        logic drv_a;
        logic drv_b;
        if (i == 0) begin : g_head
            assign link[i] = ser_in;
        end else begin : g_body
            assign link[i] = bits_q[i-1];
        end
        srm_drive u_drv (
            .rw    (rw),
            .din   (link[i]),
            .drv_a (drv_a),
            .drv_b (drv_b)
        );
        srm_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .drv_a (drv_a),
            .drv_b (drv_b),
            .q     (bits_q[i])
        );
    end

    always_comb begin
        unique case (rw)
            1'b1:    ser_out = bits_q[BITS-1];
            default: ser_out = 1'b0;
        endcase
    end

    // R4
    row_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rw |=> $stable(bits_q));

    // R2
    row_head_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rw |=> (bits_q[0] == $past(ser_in)));

    // R2
    row_tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rw |=> (bits_q[BITS-1] == $past(bits_q[BITS-2])));
endmodule

// File: rtl/shift_row_memory.sv
module shift_row_memory #(
    parameter int ROWS = 4,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_rw,
    input  logic            ser_in,
    output logic [ROWS-1:0] ser_out
);
    localparam int CELLS = ROWS * BITS;

    initial begin
        if (BITS < 2 || ROWS < 1 || CELLS < 2) begin
            $error("shift_row_memory: needs BITS >= 2 and ROWS >= 1");
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        srm_row #(.BITS(BITS)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .rw      (row_rw[r]),
            .ser_in  (ser_in),
            .ser_out (ser_out[r])
        );
    end

    // R5
    idle_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ser_out & ~row_rw) == '0));
endmodule

// File: tb/sim_shift_row_memory.sv
module sim_shift_row_memory;
    localparam int ROWS = 4;
    localparam int BITS = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ROWS-1:0] row_rw = '0;
    logic            ser_in = 1'b0;
    logic [ROWS-1:0] ser_out;

    int checks = 0;
    int errors = 0;
    bit model [ROWS][$];
    string tag = "R1";

    always #4 clk = ~clk;

    shift_row_memory #(.ROWS(ROWS), .BITS(BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .row_rw(row_rw), .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic check_bit(string req, int row, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s row %0d actual %b expected %b at %0t", req, row, act, exp, $time);
        end
    endtask

    task automatic step(logic [ROWS-1:0] rw, logic d);
        @(negedge clk);
        row_rw = rw;
        ser_in = d;
        #1;
        for (int r = 0; r < ROWS; r++) begin
            if (rw[r]) check_bit(tag, r, ser_out[r], model[r][BITS-1]);
            else       check_bit("R5", r, ser_out[r], 1'b0);
        end
        for (int r = 0; r < ROWS; r++) begin
            if (rw[r]) begin
                model[r].push_front(d);
                void'(model[r].pop_back());
            end
        end
    endtask

    task automatic unload_row(int row, logic [BITS-1:0] exp);
        logic [BITS-1:0] got;
        got = '0;
        tag = "R8";
        for (int k = 0; k < BITS; k++) begin
            @(negedge clk);
            row_rw = '0;
            row_rw[row] = 1'b1;
            ser_in = k[0];
            #1;
            got[k] = ser_out[row];
            model[row].push_front(k[0]);
            void'(model[row].pop_back());
        end
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R8 row %0d actual %h expected %h", row, got, exp);
        end
    endtask

    initial begin
        logic [BITS-1:0] pat [ROWS];
        logic [BITS-1:0] all_pat;
        for (int r = 0; r < ROWS; r++) begin
            model[r] = {};
            for (int k = 0; k < BITS; k++) model[r].push_back(1'b0);
        end
        // R1: outputs idle during reset
        repeat (3) begin
            @(negedge clk);
            for (int r = 0; r < ROWS; r++) check_bit("R1", r, ser_out[r], 1'b0);
        end
        rst_n = 1'b1;
        // R1 / R7: all rows load together, reset contents come out
        all_pat = 8'h3C;
        tag = "R1";
        for (int k = 0; k < BITS; k++) step({ROWS{1'b1}}, all_pat[k]);
        // R6 / R3: each row alone reads old data while new data enters
        for (int r = 0; r < ROWS; r++) begin
            pat[r] = 8'hA5 ^ 8'(r * 37);
            tag = "R6";
            for (int k = 0; k < BITS; k++) step(ROWS'(1) << r, pat[r][k]);
        end
        // R4: idle rows ignore a toggling input
        tag = "R4";
        for (int k = 0; k < 10; k++) step('0, k[0] ^ k[2]);
        // R9: pause row 1 mid-transfer, then finish
        tag = "R9";
        for (int k = 0; k < 3; k++) step(4'b0010, 1'b1);
        for (int k = 0; k < 4; k++) step(4'b0000, 1'b1);
        for (int k = 0; k < BITS - 3; k++) step(4'b0010, 1'b0);
        pat[1] = '0;
        pat[1][2:0] = 3'b111;
        // R2 / R3: shift a pattern with both values through row 3
        tag = "R2";
        pat[3] = 8'h96;
        for (int k = 0; k < BITS; k++) step(4'b1000, pat[3][k]);
        // R8: unload every row, same latency each
        for (int r = 0; r < ROWS; r++) unload_row(r, pat[r]);
        // R5: all idle at the end
        tag = "R5";
        step('0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule